// File: doc/BRIEF.md
# Special-Purpose Register Access Unit

This block serves the move-to and move-from special-register operations of a small processor core. Each operation gives a base operand and a 16-bit immediate. Their bitwise OR is the register address: a 5-bit group in bits 15:11 and an 11-bit number in bits 10:0. The unit holds the system registers: version, next and previous program counter, status, exception program counter, exception effective address and exception status. It also holds read-only configuration words, a match array and a translate array for each of the data-side and instruction-side translation buffers, and an interrupt mask and pending pair.

A read returns its value in the same cycle, because the data path is combinational. When the address is unmapped or the operation is refused, the read returns the old contents of the destination register, which the pipeline supplies on `rd_prev`. A write takes effect on the next rising clock edge. Some writes have side effects, and these come out as one-cycle pulses in the cycle after the write. A change to a mode bit of the status register raises a full translation-buffer flush. Clearing the valid bit of a match entry raises a single-page invalidate that carries the page address of the old entry. The unit performs an operation only while the status register shows supervisor mode. In user mode it ignores the operation and sets a sticky illegal-access flag.

Top module: `sreg_access_unit`

## Requirements
- R1: The effective address is `base_val | {16'b0, imm_off}`. The group is taken from address bits 15:11 and the number from bits 10:0. Any set bit in address bits 31:16 makes the access unmapped.
- R2: A write to the status register (group 0, number 17) stores the written data with bit 15 forced to 1. After reset the status register reads 32'h0000_8001.
- R3: A status write that changes bit 0 (supervisor), bit 5 (data translation enable) or bit 6 (instruction translation enable) drives `flush_all` high for exactly the one cycle after the write. A status write that changes none of these bits leaves `flush_all` low.
- R4: Data-side match entries sit at group 1, numbers 512+i, and translate entries at group 1, numbers 640+i, for i below TLB_DEPTH (16). The instruction side uses the same numbers in group 2. A written entry reads back its value.
- R5: A match write whose data has bit 0 clear drives `page_inval` for one cycle after the write. In that cycle `page_inval_addr` holds the old entry with bits 12:0 cleared, and `page_inval_instr` is 1 for the instruction side and 0 for the data side. A match write with bit 0 set gives no pulse.
- R6: Writes to unmapped addresses change nothing, and reads from them return `rd_prev`. Unmapped addresses include group 1 and group 2 numbers 768 to 1535, TLB numbers at or beyond the depth, and any address not listed in R2, R4, R7, R8, R9 or R10.
- R7: A write to the interrupt mask (group 9, number 0) ORs the data into the mask. A mask bit is never cleared except by reset, which sets the mask to 0.
- R8: A write to interrupt pending (group 9, number 2) clears each bit written as 1. Each cycle, every set bit of `irq_lines` sets the matching pending bit, and a set takes priority over a clear in the same cycle. After reset the pending register reads 0.
- R9: Group 0, numbers 1 to 4 return the fixed values 32'h0000_0019, 32'h0000_0020, 32'h0000_0018 and 32'h0000_0018. Writes to them have no effect.
- R10: Group 0 numbers 0, 16, 18, 32, 48 and 64 are plain read/write registers. After reset they hold 32'h0000_0012 (number 0) and 0 (the rest).
- R11: While status bit 0 is clear, an operation changes no state and a read returns `rd_prev`. The operation also sets `illegal_flag` on the next cycle, and the flag stays set until reset.
- R12: A read returns its data in the same cycle. A written value is visible to a read from the next cycle on. After reset `flush_all`, `page_inval` and `illegal_flag` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | An operation is presented this cycle |
| op_write | input | 1 | 1 = move-to (write), 0 = move-from (read) |
| base_val | input | 32 | Base operand of the address |
| imm_off | input | 16 | Immediate offset of the address |
| wr_data | input | 32 | Data to write |
| rd_prev | input | 32 | Current destination register value |
| irq_lines | input | NIRQ | Interrupt sources that set pending bits |
| rd_data | output | 32 | Read result, combinational |
| flush_all | output | 1 | One-cycle full translation-buffer flush |
| page_inval | output | 1 | One-cycle single-page invalidate |
| page_inval_instr | output | 1 | Invalidate targets the instruction side |
| page_inval_addr | output | 32 | Page address to invalidate |
| illegal_flag | output | 1 | Sticky user-mode access flag |

## Verification
Every register has a read path, so a wrong value in any of them shows up at the first read of that address, in the same cycle as the read. The bench compares every read against a model of the register file. Wrong mode-bit or valid-bit handling shows up in the cycle right after the write, as a missing, extra or misaddressed flush or invalidate pulse. A decode error, such as a range set too wide, shows up as a read that returns stored data where `rd_prev` was expected, or the reverse.

// File: rtl/sreg_pkg.sv
package sreg_pkg;
  localparam int SR_SM_BIT  = 0;
  localparam int SR_DME_BIT = 5;
  localparam int SR_IME_BIT = 6;
  localparam int SR_FO_BIT  = 15;
  localparam logic [31:0] SR_MODE_MASK =
    (32'd1 << SR_SM_BIT) | (32'd1 << SR_DME_BIT) | (32'd1 << SR_IME_BIT);
  localparam logic [31:0] SR_RESET = (32'd1 << SR_FO_BIT) | (32'd1 << SR_SM_BIT);

  typedef enum logic [4:0] {
    SK_UNMAPPED, SK_VER, SK_UPR, SK_CPUCFG, SK_DMMUCFG, SK_IMMUCFG,
    SK_NPC, SK_STAT, SK_PPC, SK_EPC, SK_EEA, SK_ESR,
    SK_DMATCH, SK_DXLATE, SK_IMATCH, SK_IXLATE, SK_PMASK, SK_PSTAT
  } sreg_kind_e;
endpackage

// File: rtl/sreg_decode.sv
module sreg_decode
  import sreg_pkg::*;
#(
  parameter int TLB_DEPTH = 16,
  localparam int IW = (TLB_DEPTH > 1) ? $clog2(TLB_DEPTH) : 1
) (
  input  logic [31:0]  base_val,
  input  logic [15:0]  imm_off,
  output sreg_kind_e   kind,
  output logic [IW-1:0] idx
);
  localparam logic [10:0] MATCH_LO = 11'd512;
  localparam logic [10:0] XLATE_LO = 11'd640;
  localparam logic [10:0] MATCH_HI = 11'(512 + TLB_DEPTH);
  localparam logic [10:0] XLATE_HI = 11'(640 + TLB_DEPTH);

  logic [31:0] ea;
  logic [4:0]  grp;
  logic [10:0] num;
  logic [10:0] rel_m, rel_x;

  assign ea    = base_val | {16'b0, imm_off};
  assign grp   = ea[15:11];
  assign num   = ea[10:0];
  assign rel_m = num - MATCH_LO;
  assign rel_x = num - XLATE_LO;

  always_comb begin
    kind = SK_UNMAPPED;
    idx  = '0;
    if (ea[31:16] == 16'd0) begin
      unique case (grp)
        5'd0: begin
          case (num)
            11'd0:  kind = SK_VER;
            11'd1:  kind = SK_UPR;
            11'd2:  kind = SK_CPUCFG;
            11'd3:  kind = SK_DMMUCFG;
            11'd4:  kind = SK_IMMUCFG;
            11'd16: kind = SK_NPC;
            11'd17: kind = SK_STAT;
            11'd18: kind = SK_PPC;
            11'd32: kind = SK_EPC;
            11'd48: kind = SK_EEA;
            11'd64: kind = SK_ESR;
            default: kind = SK_UNMAPPED;
          endcase
        end
        5'd1, 5'd2: begin
          if (num >= MATCH_LO && num < MATCH_HI) begin
            kind = (grp == 5'd1) ? SK_DMATCH : SK_IMATCH;
            idx  = rel_m[IW-1:0];
          end else if (num >= XLATE_LO && num < XLATE_HI) begin
            kind = (grp == 5'd1) ? SK_DXLATE : SK_IXLATE;
            idx  = rel_x[IW-1:0];
          end
        end
        5'd9: begin
          if (num == 11'd0)      kind = SK_PMASK;
          else if (num == 11'd2) kind = SK_PSTAT;
        end
        default: kind = SK_UNMAPPED;
      endcase
    end
  end
endmodule

// File: rtl/sreg_tlb_bank.sv
module sreg_tlb_bank #(
  parameter int DEPTH     = 16,
  parameter int DW        = 32,
  parameter int PAGE_BITS = 13,
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_match,
  input  logic          wr_xlate,
  input  logic [IW-1:0] idx,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rd_match,
  output logic [DW-1:0] rd_xlate,
  output logic          inval_o,
  output logic [DW-1:0] inval_addr_o
);
  localparam logic [DW-1:0] PAGE_MASK = ~((DW'(1) << PAGE_BITS) - DW'(1));

  logic [DW-1:0] mtab [DEPTH];
  logic [DW-1:0] xtab [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_match) mtab[idx] <= wdata;
    if (wr_xlate) xtab[idx] <= wdata;
  end

  assign rd_match = mtab[idx];
  assign rd_xlate = xtab[idx];

  always_ff @(posedge clk) begin
    if (rst) begin
      inval_o      <= 1'b0;
      inval_addr_o <= '0;
    end else begin
      inval_o <= wr_match && !wdata[0];
      if (wr_match && !wdata[0]) inval_addr_o <= rd_match & PAGE_MASK;
    end
  end

  p_inval_on_clear_r5: assert property (@(posedge clk) disable iff (rst)
    (wr_match && !wdata[0]) |=> inval_o);
  p_no_inval_valid_r5: assert property (@(posedge clk) disable iff (rst)
    (!wr_match || wdata[0]) |=> !inval_o);
endmodule

// File: rtl/sreg_access_unit.sv
module sreg_access_unit
  import sreg_pkg::*;
#(
  parameter int TLB_DEPTH = 16,
  parameter int PAGE_BITS = 13,
  parameter int NIRQ      = 32,
  parameter logic [31:0] VER_RESET   = 32'h0000_0012,
  parameter logic [31:0] UPR_VAL     = 32'h0000_0019,
  parameter logic [31:0] CPUCFG_VAL  = 32'h0000_0020,
  parameter logic [31:0] DMMUCFG_VAL = 32'h0000_0018,
  parameter logic [31:0] IMMUCFG_VAL = 32'h0000_0018
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            op_valid,
  input  logic            op_write,
  input  logic [31:0]     base_val,
  input  logic [15:0]     imm_off,
  input  logic [31:0]     wr_data,
  input  logic [31:0]     rd_prev,
  input  logic [NIRQ-1:0] irq_lines,
  output logic [31:0]     rd_data,
  output logic            flush_all,
  output logic            page_inval,
  output logic            page_inval_instr,
  output logic [31:0]     page_inval_addr,
  output logic            illegal_flag
);
  localparam int IW = (TLB_DEPTH > 1) ? $clog2(TLB_DEPTH) : 1;

  sreg_kind_e   kind;
  logic [IW-1:0] idx;

  logic [31:0] vr_q, npc_q, sr_q, ppc_q, epc_q, eea_q, esr_q;
  logic [NIRQ-1:0] pmask_q, pstat_q;
  logic flush_q, illegal_q;

  logic accept, wr_en, rd_en, bad_op;
  assign accept = op_valid && sr_q[SR_SM_BIT];
  assign bad_op = op_valid && !sr_q[SR_SM_BIT];
  assign wr_en  = accept && op_write;
  assign rd_en  = accept && !op_write;

  sreg_decode #(.TLB_DEPTH(TLB_DEPTH)) u_dec (
    .base_val (base_val),
    .imm_off  (imm_off),
    .kind     (kind),
    .idx      (idx)
  );

  logic [31:0] b_match [2];
  logic [31:0] b_xlate [2];
  logic        b_inv   [2];
  logic [31:0] b_iaddr [2];

  for (genvar s = 0; s < 2; s++) begin : g_side
    localparam sreg_kind_e KM = (s == 0) ? SK_DMATCH : SK_IMATCH;
    localparam sreg_kind_e KX = (s == 0) ? SK_DXLATE : SK_IXLATE;
    sreg_tlb_bank #(.DEPTH(TLB_DEPTH), .DW(32), .PAGE_BITS(PAGE_BITS)) u_bank (
      .clk          (clk),
      .rst          (rst),
      .wr_match     (wr_en && kind == KM),
      .wr_xlate     (wr_en && kind == KX),
      .idx          (idx),
      .wdata        (wr_data),
      .rd_match     (b_match[s]),
      .rd_xlate     (b_xlate[s]),
      .inval_o      (b_inv[s]),
      .inval_addr_o (b_iaddr[s])
    );
  end

  assign page_inval       = b_inv[0] | b_inv[1];
  assign page_inval_instr = b_inv[1];
  assign page_inval_addr  = b_inv[1] ? b_iaddr[1] : b_iaddr[0];

  // System, status and interrupt registers
  always_ff @(posedge clk) begin
    if (rst) begin
      vr_q      <= VER_RESET;
      npc_q     <= '0;
      sr_q      <= SR_RESET;
      ppc_q     <= '0;
      epc_q     <= '0;
      eea_q     <= '0;
      esr_q     <= '0;
      pmask_q   <= '0;
      pstat_q   <= '0;
      flush_q   <= 1'b0;
      illegal_q <= 1'b0;
    end else begin
      flush_q   <= 1'b0;
      illegal_q <= illegal_q | bad_op;
      if (wr_en && kind == SK_PSTAT)
        pstat_q <= (pstat_q & ~wr_data[NIRQ-1:0]) | irq_lines;
      else
        pstat_q <= pstat_q | irq_lines;
      if (wr_en) begin
        case (kind)
          SK_VER:   vr_q  <= wr_data;
          SK_NPC:   npc_q <= wr_data;
          SK_PPC:   ppc_q <= wr_data;
          SK_EPC:   epc_q <= wr_data;
          SK_EEA:   eea_q <= wr_data;
          SK_ESR:   esr_q <= wr_data;
          SK_STAT: begin
            sr_q    <= wr_data | (32'd1 << SR_FO_BIT);
            flush_q <= ((sr_q ^ wr_data) & SR_MODE_MASK) != 32'd0;
          end
          SK_PMASK: pmask_q <= pmask_q | wr_data[NIRQ-1:0];
          default: ;
        endcase
      end
    end
  end

  // Combinational read path
  always_comb begin
    rd_data = rd_prev;
    if (rd_en) begin
      case (kind)
        SK_VER:     rd_data = vr_q;
        SK_UPR:     rd_data = UPR_VAL;
        SK_CPUCFG:  rd_data = CPUCFG_VAL;
        SK_DMMUCFG: rd_data = DMMUCFG_VAL;
        SK_IMMUCFG: rd_data = IMMUCFG_VAL;
        SK_NPC:     rd_data = npc_q;
        SK_STAT:    rd_data = sr_q;
        SK_PPC:     rd_data = ppc_q;
        SK_EPC:     rd_data = epc_q;
        SK_EEA:     rd_data = eea_q;
        SK_ESR:     rd_data = esr_q;
        SK_DMATCH:  rd_data = b_match[0];
        SK_DXLATE:  rd_data = b_xlate[0];
        SK_IMATCH:  rd_data = b_match[1];
        SK_IXLATE:  rd_data = b_xlate[1];
        SK_PMASK:   rd_data = 32'(pmask_q);
        SK_PSTAT:   rd_data = 32'(pstat_q);
        default:    rd_data = rd_prev;
      endcase
    end
  end

  assign flush_all    = flush_q;
  assign illegal_flag = illegal_q;

  p_fo_forced_r2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && kind == SK_STAT) |=> sr_q[SR_FO_BIT]);
  p_flush_on_mode_r3: assert property (@(posedge clk) disable iff (rst)
    flush_all |-> (($past(sr_q) ^ sr_q) & SR_MODE_MASK) != 32'd0);
  p_mask_or_r7: assert property (@(posedge clk) disable iff (rst)
    (wr_en && kind == SK_PMASK) |=>
      ((pmask_q & $past(wr_data[NIRQ-1:0])) == $past(wr_data[NIRQ-1:0])));
  p_mask_keeps_r7: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((pmask_q & $past(pmask_q)) == $past(pmask_q)));
  p_user_blocks_r11: assert property (@(posedge clk) disable iff (rst)
    bad_op |=> (npc_q == $past(npc_q) && sr_q == $past(sr_q) && illegal_flag));
  p_illegal_sticky_r11: assert property (@(posedge clk) disable iff (rst)
    illegal_flag |=> illegal_flag);
  p_one_inval_side_r5: assert property (@(posedge clk) disable iff (rst)
    !(b_inv[0] && b_inv[1]));
endmodule

// File: tb/sim_sreg_access_unit.sv
module sim_sreg_access_unit;
  localparam int DEPTH = 16;
  localparam logic [31:0] PMASK_PG = 32'hFFFF_E000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic op_valid = 1'b0, op_write = 1'b0;
  logic [31:0] base_val = '0, wr_data = '0, rd_prev = '0, irq_lines = '0;
  logic [15:0] imm_off = '0;
  logic [31:0] rd_data, page_inval_addr;
  logic flush_all, page_inval, page_inval_instr, illegal_flag;

  always #2 clk = ~clk;

  sreg_access_unit u0 (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_write(op_write),
    .base_val(base_val), .imm_off(imm_off), .wr_data(wr_data),
    .rd_prev(rd_prev), .irq_lines(irq_lines), .rd_data(rd_data),
    .flush_all(flush_all), .page_inval(page_inval),
    .page_inval_instr(page_inval_instr), .page_inval_addr(page_inval_addr),
    .illegal_flag(illegal_flag)
  );

  int unsigned nvec = 0, nbad = 0;
  bit done = 0;

  logic [31:0] m_vr = 32'h12, m_npc = 0, m_sr = 32'h8001, m_ppc = 0, m_epc = 0,
               m_eea = 0, m_esr = 0, m_pmask = 0, m_pstat = 0;
  logic [31:0] m_tlb [4][DEPTH];
  logic m_ill = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int tlb_slot(input logic [31:0] a, output int i);
    logic [4:0] g = a[15:11];
    int n = int'(a[10:0]);
    i = 0;
    if (a[31:16] != 0 || (g != 1 && g != 2)) return -1;
    if (n >= 512 && n < 512 + DEPTH) begin i = n - 512; return (g == 1) ? 0 : 2; end
    if (n >= 640 && n < 640 + DEPTH) begin i = n - 640; return (g == 1) ? 1 : 3; end
    return -1;
  endfunction

  function automatic logic [31:0] m_read(input logic [31:0] a, input logic [31:0] prev);
    int i, s;
    s = tlb_slot(a, i);
    if (s >= 0) return m_tlb[s][i];
    case (a)
      32'h0: return m_vr;
      32'h1: return 32'h19;
      32'h2: return 32'h20;
      32'h3: return 32'h18;
      32'h4: return 32'h18;
      32'd16: return m_npc;
      32'd17: return m_sr;
      32'd18: return m_ppc;
      32'd32: return m_epc;
      32'd48: return m_eea;
      32'd64: return m_esr;
      32'h4800: return m_pmask;
      32'h4802: return m_pstat;
      default: return prev;
    endcase
  endfunction

  task automatic op(input bit w, input logic [31:0] base, input logic [15:0] imm,
                    input logic [31:0] d, input logic [31:0] prev,
                    input logic [31:0] irq, input string req);
    logic [31:0] a = base | {16'b0, imm};
    logic [31:0] exp_rd, e_iaddr, clr;
    bit e_flush = 0, e_inv = 0, e_side = 0, sup;
    int i, s;
    op_valid = 1; op_write = w; base_val = base; imm_off = imm;
    wr_data = d; rd_prev = prev; irq_lines = irq;
    #1;
    sup = m_sr[0];
    exp_rd = (!w && sup) ? m_read(a, prev) : prev;
    chk({req, " read"}, rd_data, exp_rd);
    clr = 0;
    if (!sup) m_ill = 1;
    else if (w) begin
      s = tlb_slot(a, i);
      if (s >= 0) begin
        if ((s == 0 || s == 2) && !d[0]) begin
          e_inv = 1; e_side = (s == 2); e_iaddr = m_tlb[s][i] & PMASK_PG;
        end
        m_tlb[s][i] = d;
      end else case (a)
        32'h0: m_vr = d;
        32'd16: m_npc = d;
        32'd17: begin
          e_flush = ((m_sr ^ d) & 32'h61) != 0;
          m_sr = d | 32'h8000;
        end
        32'd18: m_ppc = d;
        32'd32: m_epc = d;
        32'd48: m_eea = d;
        32'd64: m_esr = d;
        32'h4800: m_pmask = m_pmask | d;
        32'h4802: clr = d;
        default: ;
      endcase
    end
    m_pstat = (m_pstat & ~clr) | irq;
    @(posedge clk); #1;
    chk({req, " flush R3"}, {31'b0, flush_all}, {31'b0, e_flush});
    chk({req, " inval R5"}, {31'b0, page_inval}, {31'b0, e_inv});
    if (e_inv) begin
      chk({req, " inval addr R5"}, page_inval_addr, e_iaddr);
      chk({req, " inval side R5"}, {31'b0, page_inval_instr}, {31'b0, e_side});
    end
    chk({req, " illegal R11"}, {31'b0, illegal_flag}, {31'b0, m_ill});
    op_valid = 0; irq_lines = 0;
    @(negedge clk);
  endtask

  task automatic acc(input bit w, input logic [31:0] a, input logic [31:0] d,
                     input logic [31:0] prev, input string req);
    logic [31:0] b = a & $urandom;
    logic [15:0] im = (a[15:0] & ~b[15:0]) | (a[15:0] & 16'($urandom));
    op(w, b, im, d, prev, 0, req);
  endtask

  function automatic logic [31:0] rnd_addr();
    int k = $urandom_range(0, 9);
    int sysn [11] = '{0, 1, 2, 3, 4, 16, 17, 18, 32, 48, 64};
    case (k)
      0, 1: return 32'(sysn[$urandom_range(0, 10)]);
      2: return 32'h0800 + 32'd512 + 32'($urandom_range(0, DEPTH - 1));
      3: return 32'h0800 + 32'd640 + 32'($urandom_range(0, DEPTH - 1));
      4: return 32'h1000 + 32'd512 + 32'($urandom_range(0, DEPTH - 1));
      5: return 32'h1000 + 32'd640 + 32'($urandom_range(0, DEPTH - 1));
      6: return ($urandom_range(0, 1) != 0) ? 32'h4800 : 32'h4802;
      7: return (32'($urandom_range(1, 2)) << 11) + 32'($urandom_range(768, 1535));
      8: return (32'($urandom_range(1, 2)) << 11) + 32'($urandom_range(512 + DEPTH, 639));
      default: return 32'h0001_0000 | 32'($urandom_range(0, 64));
    endcase
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nbad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end

  initial begin
    int unsigned sd;
    logic [31:0] a, d;
    sd = $urandom(32'd4711);
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R12: reset state of the pulse and flag outputs
    chk("R12 reset flush", {31'b0, flush_all}, 0);
    chk("R12 reset inval", {31'b0, page_inval}, 0);
    chk("R12 reset illegal", {31'b0, illegal_flag}, 0);
    acc(0, 32'd17, 0, 32'hDEAD0001, "R2 reset status");
    acc(0, 32'd0, 0, 32'h5, "R10 reset version");
    acc(0, 32'h4802, 0, 32'h7, "R8 reset pending");
    // R4: fill all translation buffer entries with valid bit set
    for (int s = 0; s < 4; s++)
      for (int i = 0; i < DEPTH; i++) begin
        a = (s < 2 ? 32'h0800 : 32'h1000) + (s % 2 == 0 ? 32'd512 : 32'd640) + 32'(i);
        acc(1, a, $urandom | 32'h1, 0, "R4 fill");
      end
    for (int i = 0; i < DEPTH; i++) acc(0, 32'h1000 + 32'd640 + 32'(i), 0, 32'h1, "R4 readback");
    // R1: split of base and immediate, and high address bits
    op(0, 32'h0000_0800, 16'd512, 0, 32'h3, 0, "R1 split");
    op(0, 32'h0001_0000, 16'd17, 0, 32'hABCD, 0, "R1 high bits");
    // R2/R3 status behaviour
    acc(1, 32'd17, 32'h0000_0001, 0, "R2 fo forced");
    acc(0, 32'd17, 0, 0, "R2 fo readback");
    acc(1, 32'd17, 32'h0000_0061, 0, "R3 mode change");
    acc(1, 32'd17, 32'h0000_0261, 0, "R3 no mode change");
    // R5: invalidate pulses on both sides
    acc(1, 32'h0800 + 32'd515, 32'h0000_1234, 0, "R5 data side");
    acc(1, 32'h1000 + 32'd512 + 32'(DEPTH - 1), 32'h0000_0000, 0, "R5 instr side");
    acc(1, 32'h1000 + 32'd512 + 32'(DEPTH - 1), 32'h0000_4001, 0, "R5 valid set");
    // R6: silent ranges and beyond-depth entries
    acc(1, 32'h0800 + 32'd768, 32'h1111, 0, "R6 write 768");
    acc(0, 32'h0800 + 32'd768, 0, 32'h55, "R6 read 768");
    acc(0, 32'h1000 + 32'd1535, 0, 32'h66, "R6 read 1535");
    acc(1, 32'h0800 + 32'd512 + 32'(DEPTH), 32'h0, 0, "R6 beyond depth");
    acc(0, 32'h0800 + 32'd512 + 32'(DEPTH), 0, 32'h77, "R6 beyond depth read");
    // R7/R8 interrupt pair
    acc(1, 32'h4800, 32'h0000_00F0, 0, "R7 mask or");
    acc(1, 32'h4800, 32'h0000_000F, 0, "R7 mask or 2");
    acc(0, 32'h4800, 0, 0, "R7 mask read");
    op(0, 32'h0, 16'h4802, 0, 0, 32'h0000_0F0F, "R8 irq set");
    op(1, 32'h0, 16'h4802, 32'h0000_0F00, 0, 32'h0000_0100, "R8 clear vs set");
    acc(0, 32'h4802, 0, 0, "R8 pending read");
    // R9: configuration words
    acc(1, 32'd2, 32'hFFFF_FFFF, 0, "R9 write ignored");
    for (int n = 1; n <= 4; n++) acc(0, 32'(n), 0, 0, "R9 config");
    // R10/R12: plain registers, write then read next cycle
    acc(1, 32'd48, 32'hCAFE_0048, 0, "R10 write");
    acc(0, 32'd48, 0, 0, "R12 next cycle read");
    // constrained random mix
    for (int k = 0; k < 3000; k++) begin
      a = rnd_addr();
      d = $urandom;
      if (a == 32'd17) d[0] = 1'b1;
      op($urandom_range(0, 1) != 0, a & $urandom,
         (a[15:0] & ~16'($urandom)) | a[15:0], d, $urandom,
         ($urandom_range(0, 7) == 0) ? $urandom : 0, "R6/R10 random");
    end
    // R11: leave supervisor mode, then everything is refused
    acc(1, 32'd17, 32'h0000_0000, 0, "R11 drop supervisor");
    acc(1, 32'd16, 32'h1234_5678, 0, "R11 write refused");
    acc(0, 32'd16, 0, 32'h0BAD_0BAD, "R11 read refused");
    acc(0, 32'd17, 0, 32'h0000_0042, "R11 status read refused");
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule